// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink that sits at the end of an on-chip trace path. While capture is on, every valid 32-bit word from the upstream source is written into an internal RAM that behaves as a ring: the write pointer wraps back to zero, and a sticky flag records that older data has been overwritten. Software reaches the block through a simple word-addressed register port. Through it, software turns capture on and off, loads a trigger countdown, asks the source to flush, and drains the RAM. Each read of the data register returns one word and steps the read pointer.

Capture can end in three ways: software clears the enable bit, a programmed number of words has followed a trigger pulse, or a requested flush completes while stop-on-flush is selected. Whatever the cause, the block can then pad with zero words so that the write pointer finishes on a whole frame boundary, and only after that does it report stopped. All register writes pass through a lock. A key value written to the lock register opens the block, and any other value written there closes it again.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, capture is off. Flush status bit 1 (stopped) reads 1. Lock status (0xFB4) bit 1 reads 1, meaning locked. Both pointers read 0. The depth register at 0x004 reads the DEPTH parameter.
- R2: While locked, a write to any address other than the lock register (0xFB0) changes nothing. Writing UNLOCK_KEY to 0xFB0 unlocks the block, and writing any other value there locks it again.
- R3: Writing 1 to control bit 0 (0x020) starts capture, and control bit 0 reads 1 while capture is active. While capture runs, each cycle with traceValid high stores traceData at the write pointer (0x018) and advances the pointer modulo DEPTH. While capture is off, trace words are not stored.
- R4: Status bit 0 (0x00C) becomes 1 when the write pointer steps from DEPTH-1 to 0. It stays 1 until software writes the write pointer.
- R5: Each read of 0x010 returns the RAM word at the read pointer (0x014) and then advances the pointer modulo DEPTH. Software may load the read pointer directly.
- R6: A write to 0x024 stores the word at the write pointer and advances the pointer. This write, and any write to either pointer, is ignored while capture is active.
- R7: A traceTrigger pulse arms the countdown held in 0x01C. Each word captured in a later cycle lowers the count by one until it reaches 0. With flush-control bit 13 set, capture stops once the count reaches 0, so exactly the programmed number of words follows the trigger.
- R8: Writing 1 to flush-control bit 6 (0x304) raises flushReq. Bit 6 reads 1 until a flushDone pulse, after which both bit 6 and flushReq return to 0.
- R9: With flush-control bit 12 set, completion of a flush during capture stops capture.
- R10: With flush-control bit 0 (formatting) set, a stop that leaves the write pointer off a multiple of FRAME_WORDS writes zero words until it is aligned, and stopped is set only then. With bit 0 clear, no padding is written.
- R11: Writing 0 to control bit 0 ends capture. Flush status bit 1 reads 1 once the stop, including any padding, has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (steps the read pointer on 0x010) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| traceValid | input | 1 | Trace word valid |
| traceData | input | 32 | Trace word |
| traceTrigger | input | 1 | Trigger pulse from the trace path |
| flushReq | output | 1 | Flush request to the trace source |
| flushDone | input | 1 | Flush completion pulse from the source |

## Verification
The assertions assume that software does not rewrite the flush-control register while stop padding is in progress. They also assume that flushDone only arrives as a response to a pending request. The bench follows both assumptions: it programs flush control only while capture is stopped or before it requests a flush, and it pulses flushDone once per request. It drives register accesses one at a time and leaves traceValid low during register writes that start or stop capture, so the number of captured words is fixed by the stimulus.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam logic [11:0] ADDR_DEPTH = 12'h004;
  localparam logic [11:0] ADDR_STAT  = 12'h00C;
  localparam logic [11:0] ADDR_RDATA = 12'h010;
  localparam logic [11:0] ADDR_RPTR  = 12'h014;
  localparam logic [11:0] ADDR_WPTR  = 12'h018;
  localparam logic [11:0] ADDR_TRIG  = 12'h01C;
  localparam logic [11:0] ADDR_CTRL  = 12'h020;
  localparam logic [11:0] ADDR_WDATA = 12'h024;
  localparam logic [11:0] ADDR_FSTAT = 12'h300;
  localparam logic [11:0] ADDR_FCTRL = 12'h304;
  localparam logic [11:0] ADDR_LOCK  = 12'hFB0;
  localparam logic [11:0] ADDR_LSTAT = 12'hFB4;

  typedef enum logic [1:0] {CAP_STOPPED, CAP_RUN, CAP_PAD} capState_e;

  typedef struct packed {
    logic captureWe;
    logic padWe;
    logic swWe;
    logic rdAdvance;
    logic setRp;
    logic setWp;
  } ramStrobe_t;
endpackage

// File: rtl/trs_datapath.sv
module trs_datapath
  import trs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ramStrobe_t       strobe,
  input  logic [31:0]      traceData,
  input  logic [31:0]      regWdata,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             wrapped,
  output logic [31:0]      rdWord
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [31:0] mem [DEPTH];
  logic        wrEn;
  logic [31:0] wrWord;
  logic [PTR_W-1:0] ptrIn;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign wrEn   = strobe.captureWe | strobe.padWe | strobe.swWe;
  assign wrWord = strobe.captureWe ? traceData : (strobe.swWe ? regWdata : 32'h0);
  assign ptrIn  = (regWdata[PTR_W-1:0] > LAST_IDX) ? '0 : regWdata[PTR_W-1:0];
  assign rdWord = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      wrapped <= 1'b0;
    end else if (strobe.setWp) begin
      wrPtr   <= ptrIn;
      wrapped <= 1'b0;
    end else if (wrEn) begin
      wrPtr <= stepPtr(wrPtr);
      if (wrPtr == LAST_IDX) wrapped <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rdPtr <= '0;
    else if (strobe.setRp)     rdPtr <= ptrIn;
    else if (strobe.rdAdvance) rdPtr <= stepPtr(rdPtr);
  end

  // R6: at most one source writes the RAM in any cycle
  assert_one_writer_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.captureWe, strobe.padWe, strobe.swWe}));

  assert_wrap_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrapped && !strobe.setWp |=> wrapped);

  assert_wp_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !strobe.setWp |=> wrPtr == stepPtr($past(wrPtr)));

  assert_rp_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAdvance && !strobe.setRp |=> rdPtr == stepPtr($past(rdPtr)));
endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl
  import trs_pkg::*;
#(
  parameter int          DEPTH       = 64,
  parameter int          PTR_W       = 6,
  parameter int          FRAME_WORDS = 4,
  parameter int          CNT_W       = 16,
  parameter logic [31:0] UNLOCK_KEY  = 32'h5EC0_0DE1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [11:0]      regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             traceValid,
  input  logic             traceTrigger,
  output logic             flushReq,
  input  logic             flushDone,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic             wrapped,
  input  logic [31:0]      rdWord,
  output ramStrobe_t       strobe
);
  localparam logic [PTR_W-1:0] FRAME_MASK = PTR_W'(FRAME_WORDS - 1);

  capState_e  state;
  logic       locked, armed, fmtEn, stopOnFlush, stopOnTrig, flushPend;
  logic [CNT_W-1:0] trigCnt;

  logic wrOk, ctrlWr, idle, startCap, trigStop, flushStop, stopNow;
  logic frameAligned, padNeed;

  assign wrOk         = regWr && !locked;
  assign ctrlWr       = wrOk && (regAddr == ADDR_CTRL);
  assign idle         = (state == CAP_STOPPED);
  assign startCap     = ctrlWr && regWdata[0] && idle;
  assign trigStop     = stopOnTrig && armed && (trigCnt == '0);
  assign flushStop    = stopOnFlush && flushPend && flushDone;
  assign stopNow      = (state == CAP_RUN) &&
                        ((ctrlWr && !regWdata[0]) || trigStop || flushStop);
  assign frameAligned = ((wrPtr & FRAME_MASK) == '0);
  assign padNeed      = (state == CAP_PAD) && fmtEn && !frameAligned;
  assign flushReq     = flushPend;

  always_comb begin
    strobe.captureWe = (state == CAP_RUN) && traceValid && !stopNow;
    strobe.padWe     = padNeed;
    strobe.swWe      = wrOk && idle && (regAddr == ADDR_WDATA);
    strobe.setRp     = wrOk && idle && (regAddr == ADDR_RPTR);
    strobe.setWp     = wrOk && idle && (regAddr == ADDR_WPTR);
    strobe.rdAdvance = regRd && (regAddr == ADDR_RDATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= CAP_STOPPED;
    else begin
      unique case (state)
        CAP_STOPPED: if (startCap) state <= CAP_RUN;
        CAP_RUN:     if (stopNow)  state <= CAP_PAD;
        CAP_PAD:     if (!padNeed) state <= CAP_STOPPED;
        default:     state <= CAP_STOPPED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked      <= 1'b1;
      armed       <= 1'b0;
      trigCnt     <= '0;
      fmtEn       <= 1'b0;
      stopOnFlush <= 1'b0;
      stopOnTrig  <= 1'b0;
      flushPend   <= 1'b0;
    end else begin
      if (regWr && regAddr == ADDR_LOCK) locked <= (regWdata != UNLOCK_KEY);

      if (startCap) armed <= 1'b0;
      else if (state == CAP_RUN && traceTrigger) armed <= 1'b1;

      if (wrOk && regAddr == ADDR_TRIG) trigCnt <= regWdata[CNT_W-1:0];
      else if (strobe.captureWe && armed && trigCnt != '0) trigCnt <= trigCnt - 1'b1;

      if (wrOk && regAddr == ADDR_FCTRL) begin
        fmtEn       <= regWdata[0];
        stopOnFlush <= regWdata[12];
        stopOnTrig  <= regWdata[13];
      end

      if (wrOk && regAddr == ADDR_FCTRL && regWdata[6]) flushPend <= 1'b1;
      else if (flushDone) flushPend <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_DEPTH: regRdata = 32'(DEPTH);
      ADDR_STAT:  regRdata[0] = wrapped;
      ADDR_RDATA: regRdata = rdWord;
      ADDR_RPTR:  regRdata = 32'(rdPtr);
      ADDR_WPTR:  regRdata = 32'(wrPtr);
      ADDR_TRIG:  regRdata = 32'(trigCnt);
      ADDR_CTRL:  regRdata[0] = !idle;
      ADDR_FSTAT: regRdata[1:0] = {idle, flushPend};
      ADDR_FCTRL: begin
        regRdata[0]  = fmtEn;
        regRdata[6]  = flushPend;
        regRdata[12] = stopOnFlush;
        regRdata[13] = stopOnTrig;
      end
      ADDR_LSTAT: regRdata[1] = locked;
      default:    regRdata = '0;
    endcase
  end

  assert_flush_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flushReq) |-> $past(flushDone));

  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    locked && regWr && regAddr != ADDR_LOCK |=> $stable({fmtEn, stopOnFlush, stopOnTrig}));

  assert_pad_aligned_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(state) == CAP_PAD && idle && $past(fmtEn) |-> frameAligned);

  assert_trig_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    state == CAP_RUN && trigStop |=> state == CAP_PAD);
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trs_pkg::*;
#(
  parameter int          DEPTH       = 64,
  parameter int          FRAME_WORDS = 4,
  parameter int          CNT_W       = 16,
  parameter logic [31:0] UNLOCK_KEY  = 32'h5EC0_0DE1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        traceValid,
  input  logic [31:0] traceData,
  input  logic        traceTrigger,
  output logic        flushReq,
  input  logic        flushDone
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ramStrobe_t       strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             wrapped;
  logic [31:0]      rdWord;

  trs_ctrl #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .FRAME_WORDS(FRAME_WORDS),
    .CNT_W(CNT_W), .UNLOCK_KEY(UNLOCK_KEY)
  ) ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .traceValid(traceValid),
    .traceTrigger(traceTrigger), .flushReq(flushReq), .flushDone(flushDone),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .wrapped(wrapped), .rdWord(rdWord),
    .strobe(strobe)
  );

  trs_datapath #(.DEPTH(DEPTH), .PTR_W(PTR_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .traceData(traceData),
    .regWdata(regWdata), .wrPtr(wrPtr), .rdPtr(rdPtr), .wrapped(wrapped),
    .rdWord(rdWord)
  );
endmodule

// File: tb/trace_ring_sink_test.sv
`timescale 1ns/1ps
module trace_ring_sink_test;
  import trs_pkg::*;

  localparam logic [31:0] KEY = 32'h5EC0_0DE1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        traceValid = 1'b0;
  logic [31:0] traceData = '0;
  logic        traceTrigger = 1'b0;
  logic        flushReq;
  logic        flushDone = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];

  always #10 clk = ~clk;

  trace_ring_sink uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .traceValid(traceValid),
    .traceData(traceData), .traceTrigger(traceTrigger), .flushReq(flushReq),
    .flushDone(flushDone)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(posedge clk); #1 regWr = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    #2 d = regRdata;
    @(posedge clk); #1 regRd = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check(req, v, exp);
  endtask

  // driver: sends one trace word, queueing it when it should land in the RAM
  task automatic sendWord(input logic [31:0] d, input bit keep);
    @(negedge clk); traceValid = 1'b1; traceData = d;
    @(posedge clk); #1 traceValid = 1'b0;
    if (keep) expQ.push_back(d);
  endtask

  // monitor: reads n words back and compares them with the queue
  task automatic drain(input string req, input int n);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      regRead(ADDR_RDATA, v);
      if (expQ.size() == 0) check(req, v, 32'hDEAD_BEEF);
      else check(req, v, expQ.pop_front());
    end
  endtask

  task automatic waitStopped(input string req);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 20 && v[1] == 1'b0; i++) regRead(ADDR_FSTAT, v);
    check(req, 32'(v[1]), 32'd1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expectReg("R1 depth", ADDR_DEPTH, 32'd64);
    expectReg("R1 stopped", ADDR_FSTAT, 32'h2);
    expectReg("R1 locked", ADDR_LSTAT, 32'h2);
    expectReg("R1 wptr", ADDR_WPTR, 32'h0);
    expectReg("R1 rptr", ADDR_RPTR, 32'h0);

    // R2 lock gating
    regWrite(ADDR_TRIG, 32'd5);
    expectReg("R2 locked write ignored", ADDR_TRIG, 32'd0);
    regWrite(ADDR_LOCK, KEY);
    expectReg("R2 unlocked", ADDR_LSTAT, 32'h0);
    regWrite(ADDR_TRIG, 32'd5);
    expectReg("R2 write after unlock", ADDR_TRIG, 32'd5);
    regWrite(ADDR_LOCK, 32'h1234_5678);
    regWrite(ADDR_TRIG, 32'd7);
    expectReg("R2 relocked write ignored", ADDR_TRIG, 32'd5);
    regWrite(ADDR_LOCK, KEY);
    regWrite(ADDR_TRIG, 32'd0);

    // R3 capture, no formatting
    sendWord(32'hBAD0_0001, 1'b0);
    expectReg("R3 no capture while off", ADDR_WPTR, 32'd0);
    regWrite(ADDR_CTRL, 32'h1);
    expectReg("R3 enable readback", ADDR_CTRL, 32'h1);
    for (int i = 0; i < 6; i++) sendWord(32'hA000_0000 + 32'(i), 1'b1);
    regWrite(ADDR_CTRL, 32'h0);
    waitStopped("R11 stopped after disable");
    expectReg("R3 wptr after six", ADDR_WPTR, 32'd6);
    expectReg("R10 no padding without formatting", ADDR_WPTR, 32'd6);
    expectReg("R4 not wrapped", ADDR_STAT, 32'h0);
    regWrite(ADDR_RPTR, 32'd0);
    drain("R5 readback", 6);
    expectReg("R5 rptr advanced", ADDR_RPTR, 32'd6);

    // R6 writes ignored while active
    regWrite(ADDR_CTRL, 32'h1);
    regWrite(ADDR_WPTR, 32'd20);
    regWrite(ADDR_WDATA, 32'hFFFF_FFFF);
    regWrite(ADDR_RPTR, 32'd30);
    regWrite(ADDR_CTRL, 32'h0);
    waitStopped("R11 stopped");
    expectReg("R6 wptr unchanged", ADDR_WPTR, 32'd6);
    expectReg("R6 rptr unchanged", ADDR_RPTR, 32'd6);

    // R6 / R4 software clear of the RAM
    regWrite(ADDR_WPTR, 32'd0);
    for (int i = 0; i < 64; i++) regWrite(ADDR_WDATA, 32'h0);
    expectReg("R6 wptr back to 0", ADDR_WPTR, 32'd0);
    expectReg("R4 wrapped after full pass", ADDR_STAT, 32'h1);
    regWrite(ADDR_WPTR, 32'd0);
    expectReg("R4 wrapped cleared by pointer write", ADDR_STAT, 32'h0);

    // R10 padding with formatting on
    regWrite(ADDR_FCTRL, 32'h1);
    regWrite(ADDR_CTRL, 32'h1);
    for (int i = 0; i < 5; i++) sendWord(32'hB000_0000 + 32'(i), 1'b1);
    for (int i = 0; i < 3; i++) expQ.push_back(32'h0);
    regWrite(ADDR_CTRL, 32'h0);
    waitStopped("R10 stopped after pad");
    expectReg("R10 wptr aligned", ADDR_WPTR, 32'd8);
    regWrite(ADDR_RPTR, 32'd0);
    drain("R10 padded frame", 8);

    // R7 trigger countdown stop
    regWrite(ADDR_WPTR, 32'd0);
    regWrite(ADDR_TRIG, 32'd3);
    regWrite(ADDR_FCTRL, 32'h2001);
    regWrite(ADDR_CTRL, 32'h1);
    sendWord(32'hC000_0000, 1'b1);
    sendWord(32'hC000_0001, 1'b1);
    @(negedge clk); traceTrigger = 1'b1;
    @(posedge clk); #1 traceTrigger = 1'b0;
    for (int i = 0; i < 5; i++) sendWord(32'hC100_0000 + 32'(i), i < 3);
    for (int i = 0; i < 3; i++) expQ.push_back(32'h0);
    waitStopped("R7 stopped by trigger");
    expectReg("R7 count reached zero", ADDR_TRIG, 32'd0);
    expectReg("R7 wptr", ADDR_WPTR, 32'd8);
    regWrite(ADDR_RPTR, 32'd0);
    drain("R7 words around trigger", 8);

    // R8 / R9 flush handshake
    regWrite(ADDR_WPTR, 32'd0);
    regWrite(ADDR_FCTRL, 32'h1000);
    regWrite(ADDR_CTRL, 32'h1);
    for (int i = 0; i < 3; i++) sendWord(32'hD000_0000 + 32'(i), 1'b1);
    regWrite(ADDR_FCTRL, 32'h1040);
    @(negedge clk); #2 check("R8 flushReq raised", 32'(flushReq), 32'd1);
    expectReg("R8 flush bit pending", ADDR_FCTRL, 32'h1040);
    for (int i = 0; i < 2; i++) sendWord(32'hD100_0000 + 32'(i), 1'b1);
    @(negedge clk); flushDone = 1'b1;
    @(posedge clk); #1 flushDone = 1'b0;
    @(negedge clk); #2 check("R8 flushReq released", 32'(flushReq), 32'd0);
    expectReg("R8 flush bit self-cleared", ADDR_FCTRL, 32'h1000);
    waitStopped("R9 stop on flush");
    expectReg("R9 ctrl off", ADDR_CTRL, 32'h0);
    expectReg("R9 wptr", ADDR_WPTR, 32'd5);
    regWrite(ADDR_RPTR, 32'd0);
    drain("R9 flush words", 5);

    // R4 / R5 wrap during capture
    regWrite(ADDR_FCTRL, 32'h0);
    regWrite(ADDR_WPTR, 32'd60);
    regWrite(ADDR_CTRL, 32'h1);
    for (int i = 0; i < 6; i++) sendWord(32'hE000_0000 + 32'(i), 1'b1);
    regWrite(ADDR_CTRL, 32'h0);
    waitStopped("R11 stopped");
    expectReg("R4 wptr wrapped", ADDR_WPTR, 32'd2);
    expectReg("R4 wrap flag", ADDR_STAT, 32'h1);
    regWrite(ADDR_RPTR, 32'd60);
    drain("R5 read across wrap", 6);
    expectReg("R5 rptr wrapped", ADDR_RPTR, 32'd2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule